// File: doc/BRIEF.md
# Configurable Multi-Level Pipeline Register Bank

This block keeps four data registers, named A1, A2, B1 and B2, and arranges them on each rising clock edge according to a 2-bit operation code. The registers can act as a single four-deep delay chain, or the A pair or the B pair can act alone as a two-deep chain while the other pair keeps its contents. The operation code can also freeze every register. A synchronous reset clears the whole bank.

A separate 2-bit read select picks any one of the four registers for the output port. The read path is purely combinational, so the select is independent of whatever operation is being applied. An active-low output enable gates the output. When the output is disabled, it floats to high impedance, or to all zeros if the build option for a driven bus is chosen.

Top module: `pipe_bank4`

## Requirements
- R1: When `rst` is high at a rising clock edge, all four registers become zero whatever the operation code, and reset takes precedence over every operation.
- R2: With `cfg_op` = 0 (chain mode), one edge moves `d_in` into A1, A1 into A2, A2 into B1 and B1 into B2, all at the same time.
- R3: With `cfg_op` = 1 (B pair mode), one edge moves `d_in` into B1 and B1 into B2, and A1 and A2 keep their values.
- R4: With `cfg_op` = 2 (A pair mode), one edge moves `d_in` into A1 and A1 into A2, and B1 and B2 keep their values.
- R5: With `cfg_op` = 3 (freeze), no register changes on the edge.
- R6: With `out_en_n` low, `y_out` shows B2 for `rd_sel` = 0, B1 for 1, A2 for 2 and A1 for 3. This path is combinational and does not depend on `cfg_op`. Changes to `d_in` and `cfg_op` between edges do not alter the registers or `y_out`.
- R7: With `out_en_n` high, `y_out` is high impedance; a two-state simulator may show this as all zeros. With `out_en_n` low, the selected register is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high clear of all registers |
| d_in | input | DATA_W | Data loaded into the first level of the active chain |
| cfg_op | input | 2 | Operation: 0 chain, 1 B pair, 2 A pair, 3 freeze |
| rd_sel | input | 2 | Read select: 0 B2, 1 B1, 2 A2, 3 A1 |
| out_en_n | input | 1 | Active-low output enable |
| y_out | output | DATA_W | Selected register, or high impedance when disabled |

## Verification
The bench builds the block with DATA_W = 8 and the high-impedance output variant. At that width, random data together with the fixed all-ones and all-zero words make every lane of every register toggle. After each edge, and again between edges after the inputs have changed, the bench reads all four select values and both enable states. This checks the whole register bank against an arithmetic model on every cycle. A long run of random operation codes covers every ordered pair of consecutive modes, and a reset is applied under each mode.

// File: rtl/pipe_bank_pkg.sv
package pipe_bank_pkg;

   // Operation codes; the numeric values are fixed by the port contract.
   typedef enum logic [1:0] {
      OP_CHAIN  = 2'd0,
      OP_PAIR_B = 2'd1,
      OP_PAIR_A = 2'd2,
      OP_FREEZE = 2'd3
   } pb_op_e;

   // Register positions inside the bank, in chain order.
   localparam int unsigned POS_A1  = 0;
   localparam int unsigned POS_A2  = 1;
   localparam int unsigned POS_B1  = 2;
   localparam int unsigned POS_B2  = 3;
   localparam int unsigned N_STAGE = 4;

   // Read select value -> register position (0:B2, 1:B1, 2:A2, 3:A1).
   function automatic int unsigned sel_to_pos(input logic [1:0] sel);
      return N_STAGE - 1 - int'(sel);
   endfunction

endpackage

// File: rtl/pipe_bank_ctrl.sv
module pipe_bank_ctrl
   import pipe_bank_pkg::*;
#(
   parameter int unsigned NSTG = N_STAGE
) (
   input  logic [1:0]      op_i,
   output logic [NSTG-1:0] ld_en_o,
   output logic            b1_from_in_o
);

   pb_op_e op_q;

   always_comb begin
      op_q         = pb_op_e'(op_i);
      ld_en_o      = '0;
      b1_from_in_o = 1'b0;
      unique case (op_q)
         OP_CHAIN: begin
            ld_en_o = '1;
         end
         OP_PAIR_B: begin
            ld_en_o[POS_B1] = 1'b1;
            ld_en_o[POS_B2] = 1'b1;
            b1_from_in_o    = 1'b1;
         end
         OP_PAIR_A: begin
            ld_en_o[POS_A1] = 1'b1;
            ld_en_o[POS_A2] = 1'b1;
         end
         default: begin
            ld_en_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/pipe_bank_stage.sv
module pipe_bank_stage #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              ld,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (clr) begin
         q <= '0;
      end else if (ld) begin
         q <= d;
      end
   end

endmodule

// File: rtl/pipe_bank_rdmux.sv
module pipe_bank_rdmux
   import pipe_bank_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NSTG    = N_STAGE,
   parameter bit          OUT_HIZ = 1'b1
) (
   input  logic [DATA_W-1:0] stg_i [NSTG],
   input  logic [1:0]        sel_i,
   input  logic              oe_n_i,
   output logic [DATA_W-1:0] y_o
);

   logic [DATA_W-1:0] pick;

   always_comb begin
      pick = stg_i[sel_to_pos(sel_i)];
   end

   generate
      if (OUT_HIZ) begin : g_hiz
         assign y_o = oe_n_i ? {DATA_W{1'bz}} : pick;
      end else begin : g_zero
         assign y_o = oe_n_i ? {DATA_W{1'b0}} : pick;
      end
   endgenerate

endmodule

// File: rtl/pipe_bank4.sv
module pipe_bank4
   import pipe_bank_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          OUT_HIZ = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] d_in,
   input  logic [1:0]        cfg_op,
   input  logic [1:0]        rd_sel,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] y_out
);

   localparam int unsigned NSTG = N_STAGE;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pipe_bank4: DATA_W must be at least 1");
      end
   endgenerate

   logic [NSTG-1:0]   ld_en;
   logic              b1_from_in;
   logic [DATA_W-1:0] stg_d [NSTG];
   logic [DATA_W-1:0] stg_q [NSTG];

   pipe_bank_ctrl #(.NSTG(NSTG)) u_ctrl (
      .op_i         (cfg_op),
      .ld_en_o      (ld_en),
      .b1_from_in_o (b1_from_in)
   );

   // Source selection per level: A1 always takes the input, B1 takes the
   // input in B pair mode and A2 otherwise, the others take their predecessor.
   generate
      for (genvar i = 0; i < NSTG; i++) begin : g_stage
         if (i == POS_A1) begin : g_src_in
            assign stg_d[i] = d_in;
         end else if (i == POS_B1) begin : g_src_mux
            assign stg_d[i] = b1_from_in ? d_in : stg_q[i-1];
         end else begin : g_src_prev
            assign stg_d[i] = stg_q[i-1];
         end

         pipe_bank_stage #(.DATA_W(DATA_W)) u_reg (
            .clk (clk),
            .clr (rst),
            .ld  (ld_en[i]),
            .d   (stg_d[i]),
            .q   (stg_q[i])
         );
      end
   endgenerate

   pipe_bank_rdmux #(
      .DATA_W  (DATA_W),
      .NSTG    (NSTG),
      .OUT_HIZ (OUT_HIZ)
   ) u_rdmux (
      .stg_i  (stg_q),
      .sel_i  (rd_sel),
      .oe_n_i (out_en_n),
      .y_o    (y_out)
   );

endmodule

// File: rtl/pipe_bank4_chk.sv
module pipe_bank4_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] d_in,
   input logic [1:0]        cfg_op,
   input logic [1:0]        rd_sel,
   input logic              out_en_n,
   input logic [DATA_W-1:0] y_out,
   input logic [DATA_W-1:0] a1,
   input logic [DATA_W-1:0] a2,
   input logic [DATA_W-1:0] b1,
   input logic [DATA_W-1:0] b2
);

   AST_RST_CLEARS: assert property (@(posedge clk)
      rst |=> (a1 == '0 && a2 == '0 && b1 == '0 && b2 == '0)); // R1

   AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (cfg_op == 2'd0) |=> (a1 == $past(d_in) && a2 == $past(a1) &&
                            b1 == $past(a2) && b2 == $past(b1))); // R2

   AST_PAIR_B_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (cfg_op == 2'd1) |=> (b1 == $past(d_in) && b2 == $past(b1) &&
                            $stable(a1) && $stable(a2))); // R3

   AST_PAIR_A_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (cfg_op == 2'd2) |=> (a1 == $past(d_in) && a2 == $past(a1) &&
                            $stable(b1) && $stable(b2))); // R4

   AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (cfg_op == 2'd3) |=> ($stable(a1) && $stable(a2) &&
                            $stable(b1) && $stable(b2))); // R5

   AST_READ_MAP: assert property (@(posedge clk) disable iff (rst)
      !out_en_n |-> ((rd_sel == 2'd0 && y_out == b2) ||
                     (rd_sel == 2'd1 && y_out == b1) ||
                     (rd_sel == 2'd2 && y_out == a2) ||
                     (rd_sel == 2'd3 && y_out == a1))); // R6

endmodule

bind pipe_bank4 pipe_bank4_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .d_in     (d_in),
   .cfg_op   (cfg_op),
   .rd_sel   (rd_sel),
   .out_en_n (out_en_n),
   .y_out    (y_out),
   .a1       (stg_q[0]),
   .a2       (stg_q[1]),
   .b1       (stg_q[2]),
   .b2       (stg_q[3])
);

// File: tb/sim_pipe_bank4.sv
`timescale 1ns/100ps
module sim_pipe_bank4;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] d_in;
   logic [1:0]   cfg_op;
   logic [1:0]   rd_sel;
   logic         out_en_n;
   wire  [W-1:0] y_out;

   always #2.5 clk = ~clk;

   pipe_bank4 #(.DATA_W(W)) u0 (
      .clk      (clk),
      .rst      (rst),
      .d_in     (d_in),
      .cfg_op   (cfg_op),
      .rd_sel   (rd_sel),
      .out_en_n (out_en_n),
      .y_out    (y_out)
   );

   // Reference bank: index 0 A1, 1 A2, 2 B1, 3 B2.
   logic [W-1:0] mdl [4];
   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   task automatic chk(input bit ok, input string req,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string op_req(input logic [1:0] op);
      case (op)
         2'd0:    return "R2";
         2'd1:    return "R3";
         2'd2:    return "R4";
         default: return "R5";
      endcase
   endfunction

   // Read every register through the mux (R6), then the disabled state (R7).
   task automatic sweep(input string req);
      out_en_n = 1'b0;
      for (int s = 0; s < 4; s++) begin
         rd_sel = 2'(s);
         #0.3;
         chk(y_out === mdl[3-s], {req, "/R6"}, y_out, mdl[3-s]);
      end
      out_en_n = 1'b1;
      #0.3;
      chk((y_out === {W{1'bz}}) || (y_out === {W{1'b0}}), "R7 disabled",
          y_out, {W{1'bz}});
      out_en_n = 1'b0;
   endtask

   task automatic step(input bit r, input logic [1:0] op, input logic [W-1:0] d);
      @(negedge clk);
      rst    = r;
      cfg_op = op;
      d_in   = d;
      #0.3;
      sweep("R6 between edges");
      @(posedge clk);
      if (r) begin
         for (int k = 0; k < 4; k++) mdl[k] = '0;
      end else begin
         case (op)
            2'd0: begin
               mdl[3] = mdl[2]; mdl[2] = mdl[1]; mdl[1] = mdl[0]; mdl[0] = d;
            end
            2'd1: begin
               mdl[3] = mdl[2]; mdl[2] = d;
            end
            2'd2: begin
               mdl[1] = mdl[0]; mdl[0] = d;
            end
            default: ;
         endcase
      end
      #0.3;
      sweep(r ? "R1" : op_req(op));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog (R1..): actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; cfg_op = 2'd3; d_in = '0; rd_sel = '0; out_en_n = 1'b0;
      for (int k = 0; k < 4; k++) mdl[k] = '0;
      repeat (2) @(posedge clk);
      #0.3;
      sweep("R1 reset state");

      // Fill through the chain with boundary words (R2).
      step(1'b0, 2'd0, 8'hFF);
      step(1'b0, 2'd0, 8'h00);
      step(1'b0, 2'd0, 8'hA5);
      step(1'b0, 2'd0, 8'h5A);
      // Each pair alone, then freeze (R3, R4, R5).
      step(1'b0, 2'd1, 8'hFF);
      step(1'b0, 2'd2, 8'h00);
      step(1'b0, 2'd3, 8'h3C);
      step(1'b0, 2'd3, 8'hC3);

      // Reset under every operation code (R1).
      for (int op = 0; op < 4; op++) begin
         for (int j = 0; j < 5; j++) step(1'b0, 2'(j % 4), 8'($urandom));
         step(1'b1, 2'(op), 8'hFF);
      end

      // Long random run over all mode transitions.
      for (int i = 0; i < 800; i++) begin
         step(1'b0, 2'($urandom_range(0, 3)), 8'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule